// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter

This block is a small binary counter, four bits wide by default, that counts up or down. It has no direction input. It has two strobe inputs instead, one for counting up and one for counting down. A step happens when one strobe makes a low-to-high transition while the other strobe stays high. A free-running system clock samples both strobes through a two-flop synchronizer. A rising edge is recognised when the newest synchronized sample is high and the one before it was low. The count changes by at most one for each recognised edge.

A synchronous active-high clear sets the count to zero, and it wins over every other input. An active-low load copies the data inputs into the count on each clock while it is held low, and the strobes have no effect during that time. Two active-low outputs, carry and borrow, report terminal counts. Carry is low while the count is at its maximum and the synchronized up strobe is low. Borrow is low while the count is zero and the synchronized down strobe is low. When the strobe returns high, the pulse ends, which gives a rising edge. This lets identical stages be chained by wiring carry into the next stage's up input and borrow into its down input.

Feeding borrow back into load makes the counter a modulo-N divider, where the preset value on the data inputs sets N.

Top module: `dsc_counter`

## Requirements
- R1: While `rst` is high, on every clock edge the count is set to 0, the synchronizer flops are set high (idle), and `carry_n_o` and `borrow_n_o` read 1 afterwards.
- R2: A rising transition on `up_i` while `dn_i` is held high increments `q_o` by one, wrapping from 15 to 0. `q_o` takes the new value on the third rising clock edge after the input change.
- R3: A rising transition on `dn_i` while `up_i` is held high decrements `q_o` by one, wrapping from 0 to 15, with the same latency as R2.
- R4: The count is left unchanged in two cases: both strobes rise in the same sample, or one strobe rises while the other is low.
- R5: `clr_i` high sets `q_o` to 0 on the next clock edge. It overrides a low `load_n_i` and any strobe activity.
- R6: While `load_n_i` is low and `clr_i` is low, `q_o` takes `data_i` on each clock edge, and strobe transitions have no effect.
- R7: `borrow_n_o` is 0 exactly when `q_o` is 0 and the synchronized `dn_i` is low. Otherwise it is 1, including at count 0 with `dn_i` high.
- R8: `carry_n_o` is 0 exactly when `q_o` is 15 and the synchronized `up_i` is low. Otherwise it is 1.
- R9: Two stages chained as carry to up and borrow to down form an 8-bit counter that counts up from 0xFF to 0x00 and down from 0x00 to 0xFF.
- R10: With `borrow_n_o` ANDed into `load_n_i` and preset P on `data_i`, down pulses cycle the count through P-1 down to 0 and then back to P-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| up_i | input | 1 | Up-count strobe, acts on its rising edge |
| dn_i | input | 1 | Down-count strobe, acts on its rising edge |
| clr_i | input | 1 | Active-high clear, highest priority |
| load_n_i | input | 1 | Active-low parallel load |
| data_i | input | W | Preset value for load |
| q_o | output | W | Current count |
| carry_n_o | output | 1 | Active-low terminal-count-up pulse |
| borrow_n_o | output | 1 | Active-low terminal-count-down pulse |

## Verification
A strobe change reaches the count three clock edges after it is driven: two synchronizer edges, then the count register. The bench therefore waits four cycles after each strobe transition before sampling, and it samples on the falling edge. Clear and load land on the first edge after they are applied, so they are sampled one cycle later. Carry and borrow follow the second synchronizer flop, so they are checked three cycles after the strobe falls. In the cascade, the second stage lags by a further three edges after the first stage's pulse ends, so the high phase of each strobe pulse lasts six cycles.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;

  localparam int unsigned N_STROBES = 2;
  localparam int unsigned IDX_UP    = 0;
  localparam int unsigned IDX_DN    = 1;
endpackage

// File: rtl/dsc_strobe_sync.sv
module dsc_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  // idle level of a strobe is high, so reset to 1 avoids a false edge
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], strobe_i};
      prev_q  <= chain_q[LAST];
    end
  end

  assign level_o = chain_q[LAST];
  assign rise_o  = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/dsc_step_decode.sv
module dsc_step_decode
  import dsc_pkg::*;
(
  input  logic  up_lvl_i,
  input  logic  up_rise_i,
  input  logic  dn_lvl_i,
  input  logic  dn_rise_i,
  output step_e step_o
);
  always_comb begin
    step_o = STEP_HOLD;
    if (up_rise_i && dn_lvl_i && !dn_rise_i)
      step_o = STEP_INC;
    else if (dn_rise_i && up_lvl_i && !up_rise_i)
      step_o = STEP_DEC;
  end
endmodule

// File: rtl/dsc_count_reg.sv
module dsc_count_reg
  import dsc_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         load_n_i,
  input  logic [W-1:0] data_i,
  input  step_e        step_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      q_r <= '0;
    end else if (!load_n_i) begin
      q_r <= data_i;
    end else begin
      unique case (step_i)
        STEP_INC: q_r <= q_r + ONE;
        STEP_DEC: q_r <= q_r - ONE;
        default:  q_r <= q_r;
      endcase
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/dsc_terminal.sv
module dsc_terminal #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] q_i,
  input  logic         up_lvl_i,
  input  logic         dn_lvl_i,
  output logic         carry_n_o,
  output logic         borrow_n_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign carry_n_o  = ~((q_i == TOP) & ~up_lvl_i);
  assign borrow_n_o = ~((q_i == '0)  & ~dn_lvl_i);
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter
  import dsc_pkg::*;
#(
  parameter int unsigned W           = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_i,
  input  logic         dn_i,
  input  logic         clr_i,
  input  logic         load_n_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o,
  output logic         carry_n_o,
  output logic         borrow_n_o
);
  logic [N_STROBES-1:0] raw;
  logic [N_STROBES-1:0] lvl;
  logic [N_STROBES-1:0] rise;
  step_e                step;
  logic [W-1:0]         q;

  assign raw[IDX_UP] = up_i;
  assign raw[IDX_DN] = dn_i;

  for (genvar g = 0; g < N_STROBES; g++) begin : g_sync
    dsc_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .strobe_i (raw[g]),
      .level_o  (lvl[g]),
      .rise_o   (rise[g])
    );
  end

  dsc_step_decode u_dec (
    .up_lvl_i  (lvl[IDX_UP]),
    .up_rise_i (rise[IDX_UP]),
    .dn_lvl_i  (lvl[IDX_DN]),
    .dn_rise_i (rise[IDX_DN]),
    .step_o    (step)
  );

  dsc_count_reg #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (clr_i),
    .load_n_i (load_n_i),
    .data_i   (data_i),
    .step_i   (step),
    .q_o      (q)
  );

  dsc_terminal #(.W(W)) u_term (
    .q_i        (q),
    .up_lvl_i   (lvl[IDX_UP]),
    .dn_lvl_i   (lvl[IDX_DN]),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

  assign q_o = q;
endmodule

// File: rtl/dsc_counter_chk.sv
module dsc_counter_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_i,
  input logic         load_n_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] q_o,
  input logic         carry_n_o,
  input logic         borrow_n_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (q_o == '0));

  // R6
  load_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !load_n_i) |=> (q_o == $past(data_i)));

  // R2 R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && load_n_i) |=> ((q_o == $past(q_o)) ||
                              (q_o == W'($past(q_o) + W'(1))) ||
                              (q_o == W'($past(q_o) - W'(1)))));

  // R7
  borrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o != '0) |-> borrow_n_o);

  // R8
  carry_top_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o != TOP) |-> carry_n_o);

  // R7 R8
  term_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (carry_n_o || borrow_n_o));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (q_o == '0 && carry_n_o && borrow_n_o));
endmodule

bind dsc_counter dsc_counter_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr_i      (clr_i),
  .load_n_i   (load_n_i),
  .data_i     (data_i),
  .q_o        (q_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o)
);

// File: tb/sim_dsc_counter.sv
module sim_dsc_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int WATCHDOG = 100000;
  localparam int NVEC = 16;
  // {op, data, expected}; op: 0 up, 1 down, 2 load, 3 clear, 4 both rise,
  // 5 up rise with down low, 6 down rise with up low
  localparam logic [11:0] VEC [NVEC] = '{
    12'h001, 12'h002, 12'h101, 12'h2DD, 12'h00E, 12'h00F, 12'h000, 12'h10F,
    12'h40F, 12'h50F, 12'h60F, 12'h300, 12'h233, 12'h102, 12'h602, 12'h003
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b1, dn = 1'b1, clr0 = 1'b0, clr1 = 1'b0, ld_n = 1'b1, mod_en = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] q0, q1;
  logic c0, b0, c1, b1, ld0_n;
  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ld0_n = ld_n & (mod_en ? b0 : 1'b1);

  dsc_counter #(.W(W)) u0 (
    .clk(clk), .rst(rst), .up_i(up), .dn_i(dn), .clr_i(clr0), .load_n_i(ld0_n),
    .data_i(data), .q_o(q0), .carry_n_o(c0), .borrow_n_o(b0)
  );

  dsc_counter #(.W(W)) u1 (
    .clk(clk), .rst(rst), .up_i(c0), .dn_i(b0), .clr_i(clr1), .load_n_i(1'b1),
    .data_i('0), .q_o(q1), .carry_n_o(c1), .borrow_n_o(b1)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic up_pulse();
    up = 1'b0; tick(4); up = 1'b1; tick(6);
  endtask

  task automatic dn_pulse();
    dn = 1'b0; tick(4); dn = 1'b1; tick(6);
  endtask

  // both strobes rise in one sample: ignored (R4)
  task automatic both_rise();
    up = 1'b0; dn = 1'b0; tick(4); up = 1'b1; dn = 1'b1; tick(6);
  endtask

  function automatic string op_req(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R6";
      4'd3: return "R5";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] e;
    tick(4);
    // R1 reset state
    chk("R1", {12'h0, q0}, 16'h0);
    chk("R1", {14'h0, c0, b0}, 16'h3);
    rst = 1'b0;
    tick(2);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] op;
      op = VEC[i][11:8];
      case (op)
        4'd0: up_pulse();
        4'd1: dn_pulse();
        4'd2: begin ld_n = 1'b0; data = VEC[i][7:4]; tick(1); ld_n = 1'b1; tick(1); end
        4'd3: begin clr0 = 1'b1; tick(1); clr0 = 1'b0; tick(1); end
        4'd4: both_rise();
        4'd5: begin dn = 1'b0; tick(4); up = 1'b0; tick(4); up = 1'b1; tick(6);
                    up = 1'b0; tick(4); up = 1'b1; dn = 1'b1; tick(6); end
        4'd6: begin up = 1'b0; tick(4); dn = 1'b0; tick(4); dn = 1'b1; tick(6);
                    dn = 1'b0; tick(4); up = 1'b1; dn = 1'b1; tick(6); end
        default: ;
      endcase
      chk(op_req(op), {12'h0, q0}, {12'h0, VEC[i][3:0]});
    end

    // R5 clear overrides load
    clr0 = 1'b1; ld_n = 1'b0; data = 4'h7; tick(1);
    chk("R5", {12'h0, q0}, 16'h0);
    ld_n = 1'b1;
    up_pulse();
    chk("R5", {12'h0, q0}, 16'h0);
    clr0 = 1'b0; tick(1);

    // R6 load ignores strobes
    ld_n = 1'b0; data = 4'h9; tick(1);
    up_pulse();
    chk("R6", {12'h0, q0}, 16'h9);
    ld_n = 1'b1; tick(1);

    // R7 borrow at zero
    clr0 = 1'b1; tick(1); clr0 = 1'b0; tick(1);
    chk("R7", {15'h0, b0}, 16'h1);
    dn = 1'b0; tick(3);
    chk("R7", {14'h0, c0, b0}, 16'h2);
    dn = 1'b1; tick(6);
    chk("R3", {12'h0, q0}, 16'hF);
    chk("R7", {15'h0, b0}, 16'h1);
    // R8 carry at max
    up = 1'b0; tick(3);
    chk("R8", {14'h0, c0, b0}, 16'h1);
    up = 1'b1; tick(6);
    chk("R8", {12'h0, q0, 3'h0, c0}, 16'h0001);

    // R9 cascade
    clr0 = 1'b1; clr1 = 1'b1; tick(1); clr0 = 1'b0; clr1 = 1'b0; tick(2);
    for (int i = 1; i <= 256; i++) begin
      up_pulse();
      if (i == 16)  chk("R9", {8'h0, q1, q0}, 16'h0010);
      if (i == 255) chk("R9", {8'h0, q1, q0}, 16'h00FF);
      if (i == 256) chk("R9", {8'h0, q1, q0}, 16'h0000);
    end
    for (int i = 1; i <= 256; i++) begin
      dn_pulse();
      if (i == 1)   chk("R9", {8'h0, q1, q0}, 16'h00FF);
      if (i == 241) chk("R9", {8'h0, q1, q0}, 16'h000F);
      if (i == 256) chk("R9", {8'h0, q1, q0}, 16'h0000);
    end

    // R10 modulo-N with preset 5
    clr0 = 1'b1; tick(1); clr0 = 1'b0; tick(1);
    data = 4'h5; mod_en = 1'b1;
    e = '0;
    for (int i = 0; i < 12; i++) begin
      dn_pulse();
      e = (e == 0) ? 4'h4 : e - 4'h1;
      chk("R10", {12'h0, q0}, {12'h0, e});
    end
    mod_en = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule